// File: doc/BRIEF.md
# TDM Transmit Staging Buffer

This block is the local store between a bus-side fetch engine and a serial TDM transmitter. The fetch engine pushes 64-bit words that it has read from channel buffers in memory. The transmitter removes one bit at a time at line rate. A 3-bit depth setting caps how many bits the store may hold. A small cap keeps transmit latency short but requires the bus side to refill sooner. A large cap allows more bus latency at the cost of more delay through the store. The worst-case delay through the store is the capped bit count divided by the bits per frame, multiplied by the frame period.

The bus-side push interface is valid/ready. A word moves on a clock edge where `wr_valid` and `wr_ready` are both high. `wr_ready` doubles as the refill request. The serial side cannot wait, so `ser_valid` only reports whether data is present, and `ser_take` removes the presented bit. If the transmitter takes a bit while the store is empty, the event is an underrun. The block then records a sticky error and keeps sending idle ones until a new word arrives. An interrupt line combines the error with an enable.

Top module: `txs_stage_buf`

## Requirements
- R1: After reset the store is empty: `wr_ready`=1, `ser_valid`=0, `ser_bit`=1, `err_udr`=0, `irq`=0.
- R2: With `cfg_depth`=N (0..7), the store never holds more than (N+1)*64 bits, and exactly N+1 words are accepted into an empty store before `wr_ready` falls.
- R3: `wr_ready` is high exactly when the stored bit count plus 64 does not exceed the ceiling. A word offered while `wr_ready` is low is dropped and never reaches `ser_bit`.
- R4: Words leave in the order they were written, each one least significant bit first. `ser_bit` shows the current head bit while `ser_valid`=1, and an edge with `ser_take`=1 advances to the next bit.
- R5: An edge where `ser_take`=1 and `ser_valid`=0 sets `err_udr` (visible after that edge). `err_udr` then stays set until cleared.
- R6: While the store is empty, `ser_bit` is 1. One edge after a word is accepted into an empty store, `ser_valid`=1 and `ser_bit` equals bit 0 of that word.
- R7: `irq` is high exactly when `err_udr`=1 and `err_en`=1.
- R8: An edge with `err_clr`=1 clears `err_udr` (write-one-to-clear). If an underrun happens on the same edge, the bit stays set.
- R9: A push and a take on the same edge both take effect, so the stored count changes by +63.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_depth | input | 3 | Ceiling setting N, allowing (N+1)*64 bits |
| wr_valid | input | 1 | Bus side offers a word |
| wr_data | input | 64 | Offered word, bit 0 sent first |
| wr_ready | output | 1 | Store can accept a word (refill request) |
| ser_take | input | 1 | Transmitter consumes the presented bit |
| ser_valid | output | 1 | Store is not empty |
| ser_bit | output | 1 | Presented bit, 1 when empty |
| err_en | input | 1 | Underrun interrupt enable |
| err_clr | input | 1 | Write-one-to-clear for the underrun bit |
| err_udr | output | 1 | Sticky underrun flag |
| irq | output | 1 | Error interrupt |

## Verification
All state changes on a clock edge. `ser_valid`, `ser_bit` and `wr_ready` are due one edge after the push or take that changes the stored count. `err_udr` is due one edge after the underrun or clear edge. `irq` follows `err_udr` and `err_en` combinationally, within the same cycle. The bench drives each input one time unit after a rising edge and reads the outputs at that same point, so every check sees the state produced by the preceding edge. Each bit of a word is compared before the take that removes it.

// File: rtl/txs_pkg.sv
package txs_pkg;
  // Ceiling in bits for a depth setting: (setting + 1) whole words.
  function automatic int unsigned ceil_bits(input int unsigned setting,
                                            input int unsigned word_w);
    return (setting + 1) * word_w;
  endfunction
endpackage

// File: rtl/txs_store.sv
module txs_store #(
  parameter int WORD_W    = 64,
  parameter int MAX_WORDS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_acc,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              pop,
  output logic              head_bit
);
  localparam int PTR_W  = $clog2(MAX_WORDS);
  localparam int BIDX_W = $clog2(WORD_W);

  logic [WORD_W-1:0] mem [MAX_WORDS];
  logic [PTR_W-1:0]  wr_ptr, rd_ptr;
  logic [BIDX_W-1:0] bit_idx;
  logic              word_done;

  assign word_done = (bit_idx == BIDX_W'(WORD_W - 1));
  assign head_bit  = mem[rd_ptr][bit_idx];

  always_ff @(posedge clk) begin
    if (wr_acc) mem[wr_ptr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      bit_idx <= '0;
    end else begin
      if (wr_acc) wr_ptr <= wr_ptr + PTR_W'(1);
      if (pop) begin
        if (word_done) begin
          bit_idx <= '0;
          rd_ptr  <= rd_ptr + PTR_W'(1);
        end else begin
          bit_idx <= bit_idx + BIDX_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/txs_level.sv
module txs_level
  import txs_pkg::*;
#(
  parameter int WORD_W   = 64,
  parameter int DEPTH_FW = 3,
  parameter int FILL_W   = 10
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [DEPTH_FW-1:0] cfg_depth,
  input  logic                wr_acc,
  input  logic                pop,
  output logic [FILL_W-1:0]   fill_bits,
  output logic                wr_ready
);
  localparam int SUM_W = FILL_W + 1;

  logic [SUM_W-1:0] ceiling, need, fill_nxt;

  assign ceiling  = SUM_W'(ceil_bits(int'(cfg_depth), WORD_W));
  assign need     = SUM_W'(fill_bits) + SUM_W'(WORD_W);
  assign wr_ready = (need <= ceiling);

  always_comb begin
    fill_nxt = SUM_W'(fill_bits);
    if (wr_acc) fill_nxt = fill_nxt + SUM_W'(WORD_W);
    if (pop)    fill_nxt = fill_nxt - SUM_W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) fill_bits <= '0;
    else        fill_bits <= FILL_W'(fill_nxt);
  end
endmodule

// File: rtl/txs_err.sv
module txs_err (
  input  logic clk,
  input  logic rst_n,
  input  logic udr_evt,
  input  logic clr,
  input  logic en,
  output logic err,
  output logic irq
);
  always_ff @(posedge clk) begin
    if (!rst_n)       err <= 1'b0;
    else if (udr_evt) err <= 1'b1;
    else if (clr)     err <= 1'b0;
  end

  assign irq = err & en;
endmodule

// File: rtl/txs_stage_buf.sv
module txs_stage_buf #(
  parameter int WORD_W   = 64,
  parameter int DEPTH_FW = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [DEPTH_FW-1:0] cfg_depth,
  input  logic                wr_valid,
  input  logic [WORD_W-1:0]   wr_data,
  output logic                wr_ready,
  input  logic                ser_take,
  output logic                ser_valid,
  output logic                ser_bit,
  input  logic                err_en,
  input  logic                err_clr,
  output logic                err_udr,
  output logic                irq
);
  localparam int MAX_WORDS = 1 << DEPTH_FW;
  localparam int MAX_BITS  = MAX_WORDS * WORD_W;
  localparam int FILL_W    = $clog2(MAX_BITS + 1);

  logic [FILL_W-1:0] fill_bits;
  logic wr_acc, pop, udr_evt, head_bit;

  assign wr_acc    = wr_valid & wr_ready;
  assign ser_valid = (fill_bits != '0);
  assign pop       = ser_take & ser_valid;
  assign udr_evt   = ser_take & ~ser_valid;
  assign ser_bit   = ser_valid ? head_bit : 1'b1;

  txs_store #(.WORD_W(WORD_W), .MAX_WORDS(MAX_WORDS)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_acc(wr_acc), .wr_data(wr_data),
    .pop(pop), .head_bit(head_bit)
  );

  txs_level #(.WORD_W(WORD_W), .DEPTH_FW(DEPTH_FW), .FILL_W(FILL_W)) u_level (
    .clk(clk), .rst_n(rst_n), .cfg_depth(cfg_depth), .wr_acc(wr_acc),
    .pop(pop), .fill_bits(fill_bits), .wr_ready(wr_ready)
  );

  txs_err u_err (
    .clk(clk), .rst_n(rst_n), .udr_evt(udr_evt), .clr(err_clr),
    .en(err_en), .err(err_udr), .irq(irq)
  );
endmodule

// File: rtl/txs_stage_chk.sv
module txs_stage_chk #(
  parameter int WORD_W   = 64,
  parameter int MAX_BITS = 512,
  parameter int FILL_W   = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_valid,
  input logic              wr_ready,
  input logic              ser_take,
  input logic              ser_valid,
  input logic              err_udr,
  input logic              err_clr,
  input logic [FILL_W-1:0] fill_bits
);
  p_no_overflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    fill_bits <= FILL_W'(MAX_BITS));

  p_push_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready && !(ser_take && ser_valid)) |=>
      (fill_bits == FILL_W'($past(fill_bits) + FILL_W'(WORD_W))));

  p_empty_ready_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_bits == '0) |-> wr_ready);

  p_udr_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_take && !ser_valid) |=> err_udr);

  p_udr_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (err_udr && !err_clr) |=> err_udr);

  p_udr_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (err_clr && !(ser_take && !ser_valid)) |=> !err_udr);
endmodule

bind txs_stage_buf txs_stage_chk #(
  .WORD_W(WORD_W), .MAX_BITS(MAX_BITS), .FILL_W(FILL_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
  .ser_take(ser_take), .ser_valid(ser_valid), .err_udr(err_udr),
  .err_clr(err_clr), .fill_bits(fill_bits)
);

// File: tb/sim_txs_stage_buf.sv
`timescale 1ns/1ps
module sim_txs_stage_buf;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [2:0] cfg_depth = 3'd0;
  logic wr_valid = 1'b0, ser_take = 1'b0, err_en = 1'b0, err_clr = 1'b0;
  logic [63:0] wr_data = '0;
  logic wr_ready, ser_valid, ser_bit, err_udr, irq;
  int n_chk = 0, n_err = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  txs_stage_buf u0 (
    .clk(clk), .rst_n(rst_n), .cfg_depth(cfg_depth), .wr_valid(wr_valid),
    .wr_data(wr_data), .wr_ready(wr_ready), .ser_take(ser_take),
    .ser_valid(ser_valid), .ser_bit(ser_bit), .err_en(err_en),
    .err_clr(err_clr), .err_udr(err_udr), .irq(irq)
  );

  task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic push(logic [63:0] d);
    wr_valid = 1'b1; wr_data = d;
    tick();
    wr_valid = 1'b0;
  endtask

  task automatic take_bit(output logic b);
    b = ser_bit;
    ser_take = 1'b1;
    tick();
    ser_take = 1'b0;
  endtask

  task automatic pop_word(logic [63:0] exp, string req);
    logic [63:0] got;
    for (int i = 0; i < 64; i++) take_bit(got[i]);
    chk(req, "word bits", got, exp);
  endtask

  // R1: state after reset
  task automatic t_reset();
    chk("R1", "wr_ready", wr_ready, 1);
    chk("R1", "ser_valid", ser_valid, 0);
    chk("R1", "ser_bit", ser_bit, 1);
    chk("R1", "err_udr", err_udr, 0);
    chk("R1", "irq", irq, 0);
  endtask

  // R2/R3: depth 0 holds one word, offered word while full is dropped
  task automatic t_depth0();
    cfg_depth = 3'd0; tick();
    push(64'hA5A5_0F0F_1234_8001);
    chk("R2", "ready after one word", wr_ready, 0);
    push(64'hFFFF_FFFF_FFFF_FFFF);
    pop_word(64'hA5A5_0F0F_1234_8001, "R4");
    chk("R3", "dropped word not stored", ser_valid, 0);
    chk("R3", "ready when empty", wr_ready, 1);
  endtask

  // R2/R4: count accepted words at a given depth, drain in order
  task automatic t_depth(logic [2:0] d);
    int n = 0;
    cfg_depth = d; tick();
    while (wr_ready && n < 16) begin
      push({32'hC0DE_0000 + 32'(n), ~(32'h5A00_0000 + 32'(n))});
      n++;
    end
    chk("R2", "accepted words", 64'(n), 64'(d) + 1);
    for (int k = 0; k < n; k++)
      pop_word({32'hC0DE_0000 + 32'(k), ~(32'h5A00_0000 + 32'(k))}, "R4");
    chk("R4", "empty after drain", ser_valid, 0);
  endtask

  // R9: push and take on the same edge
  task automatic t_simul();
    logic b;
    logic [63:0] a = 64'h0123_4567_89AB_CDEF, got;
    cfg_depth = 3'd1; tick();
    push(a);
    got[0] = ser_bit;
    wr_valid = 1'b1; wr_data = 64'hDEAD_BEEF_0BAD_F00D; ser_take = 1'b1;
    tick();
    wr_valid = 1'b0; ser_take = 1'b0;
    chk("R9", "ready at 127 bits", wr_ready, 0);
    for (int i = 1; i < 64; i++) begin take_bit(b); got[i] = b; end
    chk("R9", "first word bits", got, a);
    chk("R3", "ready at 64 bits depth1", wr_ready, 1);
    pop_word(64'hDEAD_BEEF_0BAD_F00D, "R9");
  endtask

  // R5..R8: underrun flag, idle ones, interrupt, clear
  task automatic t_underrun();
    logic b;
    err_en = 1'b0;
    chk("R6", "idle one when empty", ser_bit, 1);
    take_bit(b);
    chk("R6", "bit during underrun", b, 1);
    chk("R5", "err set", err_udr, 1);
    chk("R7", "irq masked", irq, 0);
    err_en = 1'b1; #1;
    chk("R7", "irq enabled", irq, 1);
    err_clr = 1'b1; ser_take = 1'b1; tick();
    err_clr = 1'b0; ser_take = 1'b0;
    chk("R8", "set wins over clear", err_udr, 1);
    err_clr = 1'b1; tick(); err_clr = 1'b0;
    chk("R8", "cleared", err_udr, 0);
    chk("R7", "irq low after clear", irq, 0);
    take_bit(b);
    push(64'h8000_0000_0000_0002);
    chk("R6", "valid after refill", ser_valid, 1);
    chk("R6", "resumes with bit0", ser_bit, 0);
    chk("R5", "still sticky", err_udr, 1);
    pop_word(64'h8000_0000_0000_0002, "R6");
    err_clr = 1'b1; tick(); err_clr = 1'b0;
    err_en = 1'b0;
  endtask

  initial begin
    repeat (3) tick();
    rst_n = 1'b1; tick();
    t_reset();
    t_depth0();
    t_depth(3'd2);
    t_depth(3'd7);
    t_simul();
    t_underrun();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog act=hung exp=done");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end
endmodule